// File: doc/BRIEF.md
# Transport Stream Output Formatter

The formatter receives decoded transport-stream bytes, one per clock when `in_valid` is high, together with a flag marking the first byte of a packet and a flag marking the packet as uncorrectable. It queues them in a FIFO deep enough for a whole packet. It then presents them on two outputs at once. The first is an 8-bit parallel port with its own output clock, a data-enable line, a packet-start flag and an error flag. The second is a bit-serial port with clock, data, sync and error lines.

Timing is built around a fixed byte slot of 16 system clock cycles. At the start of each slot one byte is taken from the FIFO, or the slot stays empty if the FIFO is empty. The parallel clock rises in the middle of the slot, while data and flags are held steady. The serial port shifts the same byte out MSB first over eight serial clock pulses within the same slot.

`cfg_gapped` selects between two parallel-clock variants. In the gapped variant the clock pulses only for slots that hold a byte. In the continuous variant the clock runs freely and only `par_den` marks the valid bytes. `ser_en` parks the serial pins low so that the pad logic outside the block can give those pins another use.

Top module: `tsof_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every output is 0.
- R2: Every byte that is accepted appears exactly once on `par_data`, in arrival order, with `par_den` high. The byte is held for a full 16-cycle slot and is stable at the rising edge of `par_clk`. That edge comes 8 cycles after the start of the slot.
- R3: `par_sync` is high only during the slot of a byte that entered with `in_first` high.
- R4: `in_uncor` is sampled only on a byte with `in_first` high. `par_err` is then high for every byte of that packet. `in_uncor` on any other byte is ignored, and bytes that arrive before any first byte carry `par_err` low.
- R5: With `cfg_gapped` = 1, `par_clk` pulses only in slots that hold a byte, and it stays low while the FIFO is empty.
- R6: With `cfg_gapped` = 0, `par_clk` has a period of 16 cycles whether or not data is present, and `par_den` alone marks the valid slots.
- R7: The serial port sends each byte MSB first with exactly 8 rising edges of `ser_clk`, two system cycles per bit. `ser_data` holds each bit across its rising edge, and `ser_clk` stays low in empty slots.
- R8: `ser_sync` is high for all 8 bits of a packet's first byte. `ser_err` is high for all 8 bits of every byte in an uncorrectable packet.
- R9: While `ser_en` is 0, all four serial outputs are 0 and the parallel port is unaffected.
- R10: A back-to-back burst of up to DEPTH bytes (256 by default, which covers a 188-byte packet) is delivered without loss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte strobe |
| in_data | input | 8 | Input byte |
| in_first | input | 1 | Byte is the first of a packet |
| in_uncor | input | 1 | Packet is uncorrectable (read on first byte) |
| cfg_gapped | input | 1 | 1 = gapped parallel clock, 0 = continuous |
| ser_en | input | 1 | 1 = drive serial pins, 0 = park them low |
| par_clk | output | 1 | Parallel output clock |
| par_data | output | 8 | Parallel output byte |
| par_den | output | 1 | Parallel data valid |
| par_sync | output | 1 | Packet-start flag |
| par_err | output | 1 | Uncorrectable-packet flag |
| ser_clk | output | 1 | Serial bit clock |
| ser_data | output | 1 | Serial data, MSB first |
| ser_sync | output | 1 | Serial packet-start flag |
| ser_err | output | 1 | Serial uncorrectable flag |

## Verification
In the same slot, one byte drives both the parallel strobe and the eight serial pulses, and a new byte is written into the FIFO while the head byte is popped. The bench provokes both by sending a 188-byte burst with no gaps, so that writes and slot-boundary pops coincide many times. Every byte, on both ports, is matched against one scoreboard entry queued at input time. A lost or duplicated byte, or a serial byte whose flags disagree with the parallel flags for the same slot, therefore shows up as a mismatch.

// File: rtl/tsof_pkg.sv
package tsof_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned SLOT_LEN = 2 * BYTE_W;
    localparam int unsigned PH_W     = $clog2(SLOT_LEN);
    localparam int unsigned IDX_W    = $clog2(BYTE_W);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOT_LEN - 1);
    localparam logic [PH_W-1:0] PH_MID  = PH_W'(BYTE_W);

    typedef enum logic {
        CLK_CONT   = 1'b0,
        CLK_GAPPED = 1'b1
    } clk_mode_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              first;
        logic              uncor;
    } ts_item_t;

    typedef struct packed {
        logic     valid;
        ts_item_t item;
    } ts_slot_t;

    // Bit of the byte sent at a given phase: two phases per bit, MSB first.
    function automatic logic [IDX_W-1:0] msb_first_idx(input logic [PH_W-1:0] ph);
        return IDX_W'(BYTE_W - 1) - ph[PH_W-1:1];
    endfunction

endpackage

// File: rtl/tsof_pkt_tag.sv
module tsof_pkt_tag
    import tsof_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_first,
    input  logic              in_uncor,
    output ts_item_t          item
);

    logic pkt_uncor_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pkt_uncor_q <= 1'b0;
        end else if (in_valid && in_first) begin
            pkt_uncor_q <= in_uncor;
        end
    end

    always_comb begin
        item.data  = in_data;
        item.first = in_first;
        item.uncor = in_first ? in_uncor : pkt_uncor_q;
    end

endmodule

// File: rtl/tsof_fifo.sv
module tsof_fifo
    import tsof_pkg::*;
#(
    parameter int unsigned DEPTH = 256
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  ts_item_t wr_item,
    input  logic     rd_en,
    output ts_item_t rd_item,
    output logic     empty
);

    localparam int unsigned AW = $clog2(DEPTH);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
    localparam logic [AW:0]   CNT_FULL = (AW+1)'(DEPTH);

    ts_item_t    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   cnt;
    logic          do_wr, do_rd;

    assign empty   = (cnt == '0);
    assign do_wr   = wr_en && (cnt != CNT_FULL);
    assign do_rd   = rd_en && !empty;
    assign rd_item = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wr_ptr] <= wr_item;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_wr) begin
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_rd) begin
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/tsof_slot_seq.sv
module tsof_slot_seq
    import tsof_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            fifo_empty,
    input  ts_item_t        fifo_item,
    output logic            fifo_pop,
    output logic [PH_W-1:0] ph_nx,
    output ts_slot_t        slot_nx
);

    logic [PH_W-1:0] ph_q;
    ts_slot_t        slot_q;
    logic            wrap;

    assign wrap     = (ph_q == PH_LAST);
    assign ph_nx    = wrap ? '0 : ph_q + 1'b1;
    assign fifo_pop = wrap && !fifo_empty;

    always_comb begin
        slot_nx = slot_q;
        if (wrap) begin
            slot_nx = '0;
            if (!fifo_empty) begin
                slot_nx.valid = 1'b1;
                slot_nx.item  = fifo_item;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= '0;
            slot_q <= '0;
        end else begin
            ph_q   <= ph_nx;
            slot_q <= slot_nx;
        end
    end

endmodule

// File: rtl/tsof_par_port.sv
module tsof_par_port
    import tsof_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  clk_mode_e         mode,
    input  logic [PH_W-1:0]   ph_nx,
    input  ts_slot_t          slot_nx,
    output logic              par_clk,
    output logic [BYTE_W-1:0] par_data,
    output logic              par_den,
    output logic              par_sync,
    output logic              par_err
);

    logic clk_window;
    assign clk_window = (ph_nx >= PH_MID);

    always_ff @(posedge clk) begin
        if (rst) begin
            par_clk  <= 1'b0;
            par_data <= '0;
            par_den  <= 1'b0;
            par_sync <= 1'b0;
            par_err  <= 1'b0;
        end else begin
            par_clk  <= clk_window && ((mode == CLK_CONT) || slot_nx.valid);
            par_data <= slot_nx.valid ? slot_nx.item.data : '0;
            par_den  <= slot_nx.valid;
            par_sync <= slot_nx.valid && slot_nx.item.first;
            par_err  <= slot_nx.valid && slot_nx.item.uncor;
        end
    end

endmodule

// File: rtl/tsof_ser_port.sv
module tsof_ser_port
    import tsof_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ser_en,
    input  logic [PH_W-1:0] ph_nx,
    input  ts_slot_t        slot_nx,
    output logic            ser_clk,
    output logic            ser_data,
    output logic            ser_sync,
    output logic            ser_err
);

    logic            clk_q, data_q, sync_q, err_q;
    logic [IDX_W-1:0] bit_sel;

    assign bit_sel = msb_first_idx(ph_nx);

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_q  <= 1'b0;
            data_q <= 1'b0;
            sync_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            clk_q  <= slot_nx.valid && ph_nx[0];
            data_q <= slot_nx.valid && slot_nx.item.data[bit_sel];
            sync_q <= slot_nx.valid && slot_nx.item.first;
            err_q  <= slot_nx.valid && slot_nx.item.uncor;
        end
    end

    assign ser_clk  = ser_en && clk_q;
    assign ser_data = ser_en && data_q;
    assign ser_sync = ser_en && sync_q;
    assign ser_err  = ser_en && err_q;

endmodule

// File: rtl/tsof_top.sv
module tsof_top
    import tsof_pkg::*;
#(
    parameter int unsigned DEPTH = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_first,
    input  logic              in_uncor,
    input  logic              cfg_gapped,
    input  logic              ser_en,
    output logic              par_clk,
    output logic [BYTE_W-1:0] par_data,
    output logic              par_den,
    output logic              par_sync,
    output logic              par_err,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              ser_sync,
    output logic              ser_err
);

    ts_item_t        tag_item;
    ts_item_t        head_item;
    logic            fifo_empty;
    logic            fifo_pop;
    logic [PH_W-1:0] ph_nx;
    ts_slot_t        slot_nx;
    clk_mode_e       mode;

    assign mode = clk_mode_e'(cfg_gapped);

    tsof_pkt_tag u_tag (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_first (in_first),
        .in_uncor (in_uncor),
        .item     (tag_item)
    );

    tsof_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (in_valid),
        .wr_item (tag_item),
        .rd_en   (fifo_pop),
        .rd_item (head_item),
        .empty   (fifo_empty)
    );

    tsof_slot_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .fifo_empty (fifo_empty),
        .fifo_item  (head_item),
        .fifo_pop   (fifo_pop),
        .ph_nx      (ph_nx),
        .slot_nx    (slot_nx)
    );

    tsof_par_port u_par (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .ph_nx    (ph_nx),
        .slot_nx  (slot_nx),
        .par_clk  (par_clk),
        .par_data (par_data),
        .par_den  (par_den),
        .par_sync (par_sync),
        .par_err  (par_err)
    );

    tsof_ser_port u_ser (
        .clk      (clk),
        .rst      (rst),
        .ser_en   (ser_en),
        .ph_nx    (ph_nx),
        .slot_nx  (slot_nx),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .ser_sync (ser_sync),
        .ser_err  (ser_err)
    );

endmodule

// File: rtl/tsof_checker.sv
module tsof_checker
    import tsof_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_gapped,
    input logic              ser_en,
    input logic              par_clk,
    input logic [BYTE_W-1:0] par_data,
    input logic              par_den,
    input logic              par_sync,
    input logic              par_err,
    input logic              ser_clk,
    input logic              ser_sync,
    input logic              ser_err
);

    AST_DATA_STABLE_AT_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(par_clk) |-> ($stable(par_data) && $stable(par_den))); // R2

    AST_SYNC_ONLY_VALID: assert property (@(posedge clk) disable iff (rst)
        par_sync |-> par_den); // R3

    AST_ERR_ONLY_VALID: assert property (@(posedge clk) disable iff (rst)
        par_err |-> par_den); // R4

    AST_GAPPED_NO_IDLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        ($rose(par_clk) && $past(cfg_gapped)) |-> par_den); // R5

    AST_SER_CLK_IN_SLOT: assert property (@(posedge clk) disable iff (rst)
        ser_clk |-> par_den); // R7

    AST_SER_FLAGS_MATCH: assert property (@(posedge clk) disable iff (rst)
        ser_en |-> ((ser_sync == par_sync) && (ser_err == par_err))); // R8

endmodule

bind tsof_top tsof_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_gapped (cfg_gapped),
    .ser_en     (ser_en),
    .par_clk    (par_clk),
    .par_data   (par_data),
    .par_den    (par_den),
    .par_sync   (par_sync),
    .par_err    (par_err),
    .ser_clk    (ser_clk),
    .ser_sync   (ser_sync),
    .ser_err    (ser_err)
);

// File: tb/tsof_top_bench.sv
module tsof_top_bench;
    import tsof_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic              in_valid = 1'b0;
    logic [BYTE_W-1:0] in_data = '0;
    logic              in_first = 1'b0;
    logic              in_uncor = 1'b0;
    logic              cfg_gapped = 1'b1;
    logic              ser_en = 1'b1;
    logic              par_clk, par_den, par_sync, par_err;
    logic [BYTE_W-1:0] par_data;
    logic              ser_clk, ser_data, ser_sync, ser_err;

    tsof_top u_tsof_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_first(in_first), .in_uncor(in_uncor), .cfg_gapped(cfg_gapped),
        .ser_en(ser_en), .par_clk(par_clk), .par_data(par_data),
        .par_den(par_den), .par_sync(par_sync), .par_err(par_err),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_sync(ser_sync),
        .ser_err(ser_err)
    );

    int       errs = 0;
    int       checks = 0;
    longint   cyc = 0;
    bit       done = 0;
    ts_item_t exp_par[$];
    ts_item_t exp_ser[$];
    ts_item_t pe, se;
    int       pushed = 0, popped = 0;
    int       idle_rises = 0, ser_off_bad = 0;
    bit       measure = 0, have_last = 0;
    longint   last_rise = 0;
    logic     gap_at_edge = 1'b1;
    logic     p_prev = 1'b0, s_prev = 1'b0;
    logic [7:0] sbuf = '0;
    int       nbits = 0, sync_cnt = 0, err_cnt = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        gap_at_edge <= cfg_gapped;
    end

    // Parallel monitor: scoreboard pop on each rising par_clk with data
    always @(negedge clk) begin
        if (!rst) begin
            if (par_clk && !p_prev) begin
                if (par_den) begin
                    if (exp_par.size() == 0) begin
                        chk(0, "R2", "unexpected parallel byte", par_data, 0);
                    end else begin
                        pe = exp_par.pop_front();
                        popped++;
                        chk(par_data == pe.data, "R2", "parallel byte", par_data, pe.data);
                        chk(par_sync == pe.first, "R3", "packet start flag", par_sync, pe.first);
                        chk(par_err == pe.uncor, "R4", "error flag", par_err, pe.uncor);
                    end
                end else begin
                    idle_rises++;
                    if (gap_at_edge) chk(0, "R5", "clock pulse in empty slot", 1, 0);
                end
                if (measure) begin
                    if (have_last) chk(cyc - last_rise == 16, "R6", "continuous clock period",
                                       cyc - last_rise, 16);
                    last_rise = cyc;
                    have_last = 1;
                end
            end
            p_prev = par_clk;
            if (!measure) have_last = 0;
            if (!ser_en && (ser_clk || ser_data || ser_sync || ser_err)) ser_off_bad++;
        end
    end

    // Serial monitor: collect 8 bits, then compare with the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (ser_clk && !s_prev) begin
                if (exp_ser.size() == 0) begin
                    chk(0, "R7", "serial clock with no byte pending", 1, 0);
                end else begin
                    sbuf = {sbuf[6:0], ser_data};
                    sync_cnt += int'(ser_sync);
                    err_cnt  += int'(ser_err);
                    nbits++;
                    if (nbits == 8) begin
                        se = exp_ser.pop_front();
                        chk(sbuf == se.data, "R7", "serial byte MSB first", sbuf, se.data);
                        chk(sync_cnt == (se.first ? 8 : 0), "R8", "serial sync bits", sync_cnt, se.first ? 8 : 0);
                        chk(err_cnt == (se.uncor ? 8 : 0), "R8", "serial error bits", err_cnt, se.uncor ? 8 : 0);
                        nbits = 0; sync_cnt = 0; err_cnt = 0;
                    end
                end
            end
            s_prev = ser_clk;
        end
    end

    // Driver: one byte per call, left on the bus for exactly one cycle
    task automatic put_byte(input logic [7:0] d, input bit f, input bit u,
                            input bit eu, input bit to_ser);
        in_valid = 1'b1; in_data = d; in_first = f; in_uncor = u;
        exp_par.push_back(ts_item_t'{data: d, first: f, uncor: eu});
        if (to_ser) exp_ser.push_back(ts_item_t'{data: d, first: f, uncor: eu});
        pushed++;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_pkt(input int n, input logic [7:0] seed, input bit ufirst,
                            input bit urest, input int gap, input bit to_ser);
        for (int i = 0; i < n; i++) begin
            put_byte(seed + 8'(i), i == 0, (i == 0) ? ufirst : urest, ufirst, to_ser);
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic wait_drain();
        while (exp_par.size() != 0 || exp_ser.size() != 0) @(negedge clk);
        repeat (40) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({par_clk, par_den, par_sync, par_err, par_data} == '0, "R1", "parallel outputs after reset",
            {par_clk, par_den, par_sync, par_err, par_data}, 0);
        chk({ser_clk, ser_data, ser_sync, ser_err} == 4'b0, "R1", "serial outputs after reset",
            {ser_clk, ser_data, ser_sync, ser_err}, 0);

        // R4: stray byte before any packet start, in_uncor set but ignored
        put_byte(8'hA5, 1'b0, 1'b1, 1'b0, 1'b1);
        // R3 R4: uncorrectable packet flagged on first byte only
        send_pkt(6, 8'h10, 1'b1, 1'b0, 3, 1'b1);
        // R4: good packet, in_uncor on later bytes ignored
        send_pkt(5, 8'h3C, 1'b0, 1'b1, 20, 1'b1);
        wait_drain();

        // R10: back-to-back packet burst
        send_pkt(188, 8'h47, 1'b1, 1'b0, 0, 1'b1);
        wait_drain();
        chk(popped == pushed, "R10", "bytes delivered after burst", popped, pushed);

        // R5: gapped clock idle window
        idle_rises = 0;
        repeat (200) @(negedge clk);
        chk(idle_rises == 0, "R5", "gapped idle pulses", idle_rises, 0);

        // R6: continuous clock idle window
        cfg_gapped = 1'b0;
        idle_rises = 0;
        measure = 1;
        repeat (200) @(negedge clk);
        measure = 0;
        chk(idle_rises >= 12, "R6", "continuous idle pulses", idle_rises, 12);
        send_pkt(8, 8'hC0, 1'b1, 1'b0, 0, 1'b1);
        send_pkt(3, 8'h81, 1'b0, 1'b0, 30, 1'b1);
        wait_drain();
        cfg_gapped = 1'b1;
        repeat (40) @(negedge clk);

        // R9: serial parked, parallel keeps running
        ser_en = 1'b0;
        ser_off_bad = 0;
        send_pkt(4, 8'hF1, 1'b1, 1'b0, 2, 1'b0);
        wait_drain();
        chk(ser_off_bad == 0, "R9", "serial pins while disabled", ser_off_bad, 0);
        ser_en = 1'b1;
        repeat (20) @(negedge clk);
        send_pkt(3, 8'hE0, 1'b1, 1'b1, 0, 1'b1);
        wait_drain();

        chk(exp_par.size() == 0 && exp_ser.size() == 0, "R2", "scoreboard drained",
            exp_par.size() + exp_ser.size(), 0);
        chk(popped == pushed, "R10", "total bytes delivered", popped, pushed);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule